// File: doc/BRIEF.md
# CPU Halt and Stop Sequencer

This block sits beside a small 8-bit CPU core and decides what happens when the core decodes a halt or a stop instruction. It stalls the core, holds it in a low-activity state and releases it with the right timing. At the right moments it asks the surrounding logic to move the program counter, to fetch the next opcode again, to clear the clock divider or to take an interrupt. The instruction decoder, the interrupt vectoring and the speed change itself are outside the block; it only produces the control strobes for them.

An interrupt counts as pending when a source is both flagged and enabled among the five low sources. A halt with an interrupt already pending never stalls. Instead, the block either steps the program counter back, when the global interrupt enable is set, or asks for the following opcode to be fetched twice, when it is clear. Otherwise the core sleeps until a source becomes pending. A wake can carry a four-tick penalty, which depends on the timing mode and on how soon the wake follows entry. A stop always spends a fixed cost first. With a speed change armed, it then holds the core for a long fixed stall, which ends with a divider clear and a program-counter step. Without one, it parks the core in a stopped state that only reset leaves.

States: `ST_RUN` (core running), `ST_HALT` (halted, waiting for an interrupt), `ST_HPEN` (halt wake penalty), `ST_SCOST` (fixed stop cost), `ST_SWSTALL` (speed-change stall), `ST_SWTAIL` (post-switch penalty), `ST_STOPPED` (parked). Transitions:
- run→halt on a halt strobe with nothing pending.
- run→run with a pc_dec or refetch pulse on a halt strobe while an interrupt is pending.
- run→scost on a stop strobe.
- halt→hpen on pending when fast mode is set or the wake falls inside the base window.
- halt→run on a late pending in base mode.
- hpen→run after the penalty ticks.
- scost→swstall or scost→stopped after the cost ticks.
- swstall→swtail after the switch length.
- swtail→run after the penalty ticks.
- stopped→stopped until reset.

Top module: `halt_stop_seq`

## Requirements
- R1: An interrupt is pending only when `(int_flag & int_enable & 8'h1F) != 0`. Flag bits 7..5 never count, even when they are enabled.
- R2: A halt strobe while pending with `gie=1` leaves `core_stall` low and raises `pc_dec` for exactly the one cycle after the strobe edge.
- R3: A halt strobe while pending with `gie=0` leaves `core_stall` low and raises `refetch` for exactly the one cycle after the strobe edge.
- R4: A halt strobe with nothing pending raises `core_stall` from the next cycle on, and it stays high while nothing is pending.
- R5: In base mode (`fast_mode=0`), when pending is first seen more than WAKE_WIN ticks after halt entry, `core_stall` drops one clock later. If it is seen within WAKE_WIN ticks, or in fast mode (`fast_mode=1`), PENALTY extra ticks are added before the release.
- R6: At a halt release, `wake` is a one-cycle pulse in the same cycle that `core_stall` drops, if `gie=1`. With `gie=0` no pulse occurs.
- R7: Every stop first stalls for STOP_COST ticks.
- R8: With `speed_arm=1` sampled at the stop strobe, the cost phase is followed by SWITCH_LEN stall ticks. Then `div_reset` and `pc_inc` pulse together for one cycle, and PENALTY more ticks pass before `core_stall` drops.
- R9: A stop with `speed_arm=0` keeps `core_stall` high indefinitely and ignores pending interrupts: no `wake` is raised.
- R10: Reset (`rst_n=0`) returns to the running state, with `core_stall` low and every pulse output low.
- R11: All phase lengths and the wake window count only clocks with `cyc_tick=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Machine-cycle enable; phase counters advance only on it |
| halt_req | input | 1 | Decoded halt instruction strobe |
| stop_req | input | 1 | Decoded stop instruction strobe |
| int_enable | input | 8 | Interrupt enable register |
| int_flag | input | 8 | Interrupt flag register |
| gie | input | 1 | Global interrupt enable |
| speed_arm | input | 1 | Speed change armed |
| fast_mode | input | 1 | Enhanced timing mode select |
| core_stall | output | 1 | Stall the CPU core |
| refetch | output | 1 | Fetch the next opcode twice (pulse) |
| pc_dec | output | 1 | Step program counter back by one (pulse) |
| pc_inc | output | 1 | Step program counter forward by one (pulse) |
| div_reset | output | 1 | Clear the clock divider (pulse) |
| wake | output | 1 | Interrupt wake event to vectoring logic (pulse) |

## Verification
The bench builds the block with SWITCH_LEN set to 20 instead of the default 0x20000, which keeps the whole speed-change stall, its divider-clear pulse and its tail penalty within a short run. STOP_COST, PENALTY and WAKE_WIN stay at 4, so the bench can tell a penalised wake from an unpenalised one by counting clocks. Holding the tick low during a halt shows that the wake window is measured in ticks, not clocks.

// File: rtl/halt_stop_pkg.sv
package halt_stop_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_HPEN,
        ST_SCOST,
        ST_SWSTALL,
        ST_SWTAIL,
        ST_STOPPED
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int W    = 8,
    parameter int NSRC = 5
) (
    input  logic [W-1:0] flag,
    input  logic [W-1:0] en,
    output logic         pend
);
    localparam logic [W-1:0] SRC_MASK = W'((1 << NSRC) - 1);

    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_src
        assign hit[i] = flag[i] & en[i] & SRC_MASK[i];
    end

    assign pend = |hit;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    // Counter only moves by one tick at a time or returns to zero
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt)); // R11
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import halt_stop_pkg::*;
#(
    parameter int CW         = 18,
    parameter int SWITCH_LEN = 32'h20000,
    parameter int STOP_COST  = 4,
    parameter int PENALTY    = 4,
    parameter int WAKE_WIN   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          halt_req,
    input  logic          stop_req,
    input  logic          pend,
    input  logic          gie,
    input  logic          speed_arm,
    input  logic          fast_mode,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output seq_state_e    st,
    output logic          refetch,
    output logic          pc_dec,
    output logic          pc_inc,
    output logic          div_reset,
    output logic          wake
);
    localparam logic [CW-1:0] LIM_SW   = CW'(SWITCH_LEN - 1);
    localparam logic [CW-1:0] LIM_COST = CW'(STOP_COST - 1);
    localparam logic [CW-1:0] LIM_PEN  = CW'(PENALTY - 1);
    localparam logic [CW-1:0] LIM_WIN  = CW'(WAKE_WIN);

    seq_state_e nxt;
    logic       armed_q, armed_n;
    logic       refetch_n, dec_n, inc_n, div_n, wake_n;

    // Next state and pulse requests
    always_comb begin
        nxt       = st;
        armed_n   = armed_q;
        cnt_clr   = 1'b0;
        refetch_n = 1'b0;
        dec_n     = 1'b0;
        inc_n     = 1'b0;
        div_n     = 1'b0;
        wake_n    = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (halt_req) begin
                    if (pend) begin
                        if (gie) dec_n = 1'b1;
                        else     refetch_n = 1'b1;
                    end else begin
                        nxt     = ST_HALT;
                        cnt_clr = 1'b1;
                    end
                end else if (stop_req) begin
                    nxt     = ST_SCOST;
                    cnt_clr = 1'b1;
                    armed_n = speed_arm;
                end
            end
            ST_HALT: begin
                if (pend) begin
                    if (fast_mode || cnt <= LIM_WIN) begin
                        nxt     = ST_HPEN;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt    = ST_RUN;
                        wake_n = gie;
                    end
                end
            end
            ST_HPEN: begin
                if (tick && cnt == LIM_PEN) begin
                    nxt    = ST_RUN;
                    wake_n = gie;
                end
            end
            ST_SCOST: begin
                if (tick && cnt == LIM_COST) begin
                    nxt     = armed_q ? ST_SWSTALL : ST_STOPPED;
                    cnt_clr = 1'b1;
                end
            end
            ST_SWSTALL: begin
                if (tick && cnt == LIM_SW) begin
                    nxt     = ST_SWTAIL;
                    cnt_clr = 1'b1;
                    div_n   = 1'b1;
                    inc_n   = 1'b1;
                end
            end
            ST_SWTAIL: begin
                if (tick && cnt == LIM_PEN)
                    nxt = ST_RUN;
            end
            ST_STOPPED: begin
                nxt = ST_STOPPED;
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_RUN;
            armed_q <= 1'b0;
        end else begin
            st      <= nxt;
            armed_q <= armed_n;
        end
    end

    // Registered pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refetch   <= 1'b0;
            pc_dec    <= 1'b0;
            pc_inc    <= 1'b0;
            div_reset <= 1'b0;
            wake      <= 1'b0;
        end else begin
            refetch   <= refetch_n;
            pc_dec    <= dec_n;
            pc_inc    <= inc_n;
            div_reset <= div_n;
            wake      <= wake_n;
        end
    end

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOPPED) |=> (st == ST_STOPPED)); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !pend) |=> (st == ST_HALT)); // R4
    AST_PEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HPEN && !tick) |=> (st == ST_HPEN)); // R11
endmodule

// File: rtl/halt_stop_seq.sv
module halt_stop_seq
    import halt_stop_pkg::*;
#(
    parameter int W          = 8,
    parameter int NSRC       = 5,
    parameter int SWITCH_LEN = 32'h20000,
    parameter int STOP_COST  = 4,
    parameter int PENALTY    = 4,
    parameter int WAKE_WIN   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_tick,
    input  logic         halt_req,
    input  logic         stop_req,
    input  logic [W-1:0] int_enable,
    input  logic [W-1:0] int_flag,
    input  logic         gie,
    input  logic         speed_arm,
    input  logic         fast_mode,
    output logic         core_stall,
    output logic         refetch,
    output logic         pc_dec,
    output logic         pc_inc,
    output logic         div_reset,
    output logic         wake
);
    localparam int MAXL = imax(imax(SWITCH_LEN, STOP_COST), imax(PENALTY, WAKE_WIN + 1));
    localparam int CW   = $clog2(MAXL + 1);

    logic          pend;
    logic          cnt_clr;
    logic [CW-1:0] cnt;
    seq_state_e    st;

    irq_pend #(.W(W), .NSRC(NSRC)) u_pend (
        .flag (int_flag),
        .en   (int_enable),
        .pend (pend)
    );

    tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (cyc_tick),
        .cnt   (cnt)
    );

    seq_fsm #(
        .CW         (CW),
        .SWITCH_LEN (SWITCH_LEN),
        .STOP_COST  (STOP_COST),
        .PENALTY    (PENALTY),
        .WAKE_WIN   (WAKE_WIN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cyc_tick),
        .halt_req  (halt_req),
        .stop_req  (stop_req),
        .pend      (pend),
        .gie       (gie),
        .speed_arm (speed_arm),
        .fast_mode (fast_mode),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .st        (st),
        .refetch   (refetch),
        .pc_dec    (pc_dec),
        .pc_inc    (pc_inc),
        .div_reset (div_reset),
        .wake      (wake)
    );

    assign core_stall = (st != ST_RUN);

    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (!core_stall && $past(core_stall))); // R6
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake); // R6
    AST_DEC_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_dec |-> !core_stall); // R2
    AST_REFETCH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> !core_stall); // R3
    AST_DIV_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |-> (pc_inc && core_stall)); // R8
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({refetch, pc_dec, div_reset, wake})); // R6
endmodule

// File: tb/sim_halt_stop_seq.sv
module sim_halt_stop_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b1;
    logic       halt_req = 1'b0;
    logic       stop_req = 1'b0;
    logic [7:0] int_enable = 8'h00;
    logic [7:0] int_flag = 8'h00;
    logic       gie = 1'b0;
    logic       speed_arm = 1'b0;
    logic       fast_mode = 1'b0;
    logic       core_stall, refetch, pc_dec, pc_inc, div_reset, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    halt_stop_seq #(.SWITCH_LEN(20), .STOP_COST(4), .PENALTY(4), .WAKE_WIN(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .halt_req(halt_req),
        .stop_req(stop_req), .int_enable(int_enable), .int_flag(int_flag),
        .gie(gie), .speed_arm(speed_arm), .fast_mode(fast_mode),
        .core_stall(core_stall), .refetch(refetch), .pc_dec(pc_dec),
        .pc_inc(pc_inc), .div_reset(div_reset), .wake(wake)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Clocks until core_stall drops; returns wake seen at release
    task automatic to_release(output int n, output logic w);
        n = 0;
        while (core_stall && n < 200) begin
            step();
            n++;
        end
        w = wake;
    endtask

    task automatic settle();
        int_flag = 8'h00;
        halt_req = 1'b0;
        stop_req = 1'b0;
        step();
        step();
    endtask

    task automatic t_reset_state();
        chk("R10 stall after reset", core_stall, 0);
        chk("R10 pulses after reset", {refetch, pc_dec, pc_inc, div_reset, wake}, 0);
    endtask

    task automatic t_mask_upper();
        int n; logic w;
        int_enable = 8'hFF; int_flag = 8'hE0; gie = 1'b1; fast_mode = 1'b0;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R1 upper flags not pending -> halt stalls", core_stall, 1);
        chk("R1 no pc_dec", pc_dec, 0);
        int_flag = 8'h01;
        to_release(n, w);
        chk("R5 early wake gets penalty", n, 5);
        chk("R6 wake with gie", w, 1);
        step();
        chk("R6 wake is one cycle", wake, 0);
        settle();
    endtask

    task automatic t_halt_back();
        int_enable = 8'h1F; int_flag = 8'h04; gie = 1'b1;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R2 no stall", core_stall, 0);
        chk("R2 pc_dec pulse", pc_dec, 1);
        chk("R2 no refetch", refetch, 0);
        step();
        chk("R2 pc_dec one cycle", pc_dec, 0);
        settle();
    endtask

    task automatic t_halt_skip();
        int_enable = 8'h10; int_flag = 8'h10; gie = 1'b0;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R3 no stall", core_stall, 0);
        chk("R3 refetch pulse", refetch, 1);
        chk("R3 no pc_dec", pc_dec, 0);
        step();
        chk("R3 refetch one cycle", refetch, 0);
        settle();
    endtask

    task automatic t_halt_late(input logic g, input logic fm, input int exp_n, input string tag);
        int n; logic w;
        int_enable = 8'h01; int_flag = 8'h00; gie = g; fast_mode = fm;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk({tag, " R4 stall on halt"}, core_stall, 1);
        repeat (10) step();
        chk({tag, " R4 stays halted"}, core_stall, 1);
        int_flag = 8'h01;
        to_release(n, w);
        chk({tag, " R5 release clocks"}, n, exp_n);
        chk({tag, " R6 wake at release"}, w, g);
        step();
        chk({tag, " R6 wake cleared"}, wake, 0);
        settle();
        fast_mode = 1'b0;
    endtask

    task automatic t_tick_gate();
        int n; logic w;
        int_enable = 8'h02; gie = 1'b1; fast_mode = 1'b0;
        cyc_tick = 1'b0;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        repeat (10) step();
        cyc_tick = 1'b1;
        int_flag = 8'h02;
        to_release(n, w);
        chk("R11 window counts ticks only", n, 5);
        settle();
    endtask

    task automatic t_stop_switch();
        int n; logic w;
        speed_arm = 1'b1; gie = 1'b0;
        stop_req = 1'b1; step(); stop_req = 1'b0;
        speed_arm = 1'b0;
        chk("R7 stop stalls", core_stall, 1);
        repeat (23) step();
        chk("R8 no div_reset before end", div_reset, 0);
        step();
        chk("R8 div_reset pulse", div_reset, 1);
        chk("R8 pc_inc pulse", pc_inc, 1);
        chk("R8 stall during tail", core_stall, 1);
        step();
        chk("R8 div_reset one cycle", div_reset, 0);
        to_release(n, w);
        chk("R8 tail length", n, 3);
        chk("R7 R8 no wake on switch", w, 0);
        settle();
    endtask

    task automatic t_stop_plain();
        int seen = 0;
        speed_arm = 1'b0;
        stop_req = 1'b1; step(); stop_req = 1'b0;
        int_enable = 8'h1F; int_flag = 8'h1F; gie = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step();
            if (wake) seen++;
        end
        chk("R9 still stalled", core_stall, 1);
        chk("R9 interrupts ignored", seen, 0);
        rst_n = 1'b0;
        step();
        chk("R10 reset leaves stop", core_stall, 0);
        rst_n = 1'b1;
        settle();
    endtask

    initial begin
        step();
        step();
        t_reset_state();
        rst_n = 1'b1;
        step();
        t_mask_upper();
        t_halt_back();
        t_halt_skip();
        t_halt_late(1'b1, 1'b0, 1, "base gie");
        t_halt_late(1'b0, 1'b0, 1, "base nogie");
        t_halt_late(1'b1, 1'b1, 5, "fast");
        t_tick_gate();
        t_stop_switch();
        t_stop_plain();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule